// File: doc/BRIEF.md
# Four-Format SPI Master Shifter

This block is a single-word serial master. A host pulses a start input with a data word, and the block then runs one complete exchange on a four-wire serial link. It generates the serial clock and shifts the word out most significant bit first. At the same time it assembles the word arriving on the serial input. It ends with a one-cycle completion pulse, and the received word is valid from that pulse on.

Three format bits are captured when a transfer starts:
- **Clock idle level.** Selects whether the serial clock rests low or high.
- **Clock timing.** With the aligned setting, the clock runs in step with the data: each bit is launched on a leading clock edge. With the delayed setting, the clock lags the data by half a bit: the first bit is already on the line before any clock edge.
- **Chip-select level.** Selects whether chip select is active high or active low.

A programmable divider sets the half-bit time in system clocks.

Top module: `spi_fmt_master`

## Requirements
- R1: While no transfer is in progress, `sclk_o` equals `pol_i` (0 = rests low, 1 = rests high). After reset, `busy_o` and `done_o` are low and `cs_o` is inactive. After the last clock edge of a transfer, the clock is back at the captured idle level.
- R2: With `pha_i`=1 (aligned clock), `sdo_o` is high until the first clock edge. Each bit is launched on a leading edge, meaning an edge leaving the idle level. `sdi_i` is sampled on trailing edges.
- R3: With `pha_i`=0 (delayed clock), the most significant bit is on `sdo_o` from the cycle chip select becomes active. This is before the first clock edge. `sdi_i` is sampled on leading edges, and the next bit is launched on each trailing edge.
- R4: A transfer contains exactly WORD_W clock pulses, that is WORD_W leading and WORD_W trailing edges. Bits leave most significant first.
- R5: Successive clock edges are spaced `div_i` system cycles apart, which is one half bit. A `div_i` of 0 behaves as 1.
- R6: `rx_byte_o` holds the WORD_W bits sampled from `sdi_i`, first-sampled bit in the most significant position. It is valid when `done_o` pulses. `done_o` is high for exactly one cycle, in the first cycle after `busy_o` falls.
- R7: While busy, `cs_o` equals the captured `cs_hi_i` (1 = active high). Otherwise `cs_o` equals the inverse of `cs_hi_i`. Chip select becomes active one half bit before the first clock edge. It is released one half bit after the last edge.
- R8: A start pulse while `busy_o` is high is ignored. `pol_i`, `pha_i`, `cs_hi_i`, `div_i` and `tx_byte_i` are sampled only in the cycle a start is accepted.
- R9: `sdo_o` is high whenever `busy_o` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Start request, accepted when idle |
| tx_byte_i | input | WORD_W | Word to send |
| pol_i | input | 1 | Clock idle level |
| pha_i | input | 1 | 1 = aligned clock, 0 = clock delayed half a bit |
| cs_hi_i | input | 1 | 1 = chip select active high |
| div_i | input | DIV_W | System cycles per half bit |
| rx_byte_o | output | WORD_W | Received word |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| sdi_i | input | 1 | Serial data in |
| cs_o | output | 1 | Chip select |

## Verification
The bench builds the block with WORD_W=8 and DIV_W=8. Divider settings of 0, 1, 2, 3 and 4 are therefore reachable:
- Settings 0 and 1 place clock edges on consecutive system cycles. This is where a sample edge and the following launch edge sit closest together.
- Settings 0 and 1 also make chip-select lead and lag a single cycle.
- Larger settings show that the spacing scales.

All four polarity and timing combinations are run against a behavioural slave, under both chip-select levels and with data patterns that make bit reversal and off-by-one shifting visible. A start issued mid-transfer carries altered format, divider and data inputs, which must leave the running exchange untouched.

// File: rtl/spi_fmt_pkg.sv
package spi_fmt_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_SHIFT = 2'd1,
      ST_TAIL  = 2'd2
   } spi_st_t;

   typedef struct packed {
      logic pol;
      logic pha;
      logic cs_hi;
   } spi_fmt_t;

endpackage

// File: rtl/spi_fmt_tick.sv
// Half-bit timebase: pulses once every div system cycles while run is high.
module spi_fmt_tick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic             tick
);
   logic [DIV_W-1:0] cnt_q;
   logic [DIV_W-1:0] reload;

   // a setting of 0 or 1 both give one cycle per half bit
   always_comb reload = (div <= DIV_W'(1)) ? '0 : div - DIV_W'(1);

   assign tick = run && (cnt_q == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt_q <= '0;
      else if (!run || tick)
         cnt_q <= reload;
      else
         cnt_q <= cnt_q - 1'b1;
   end
endmodule

// File: rtl/spi_fmt_shreg.sv
// Transmit and receive shift registers, MSB first.
module spi_fmt_shreg #(
   parameter int WORD_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              load,
   input  logic              lead_first,
   input  logic [WORD_W-1:0] load_data,
   input  logic              shift_out,
   input  logic              sample,
   input  logic              finish,
   input  logic              sdi,
   output logic              sdo,
   output logic [WORD_W-1:0] rx_data
);
   logic [WORD_W-1:0] tx_q;
   logic [WORD_W-1:0] rx_q;
   logic              sdo_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         tx_q  <= '0;
         rx_q  <= '0;
         sdo_q <= 1'b1;
      end else if (load) begin
         rx_q <= '0;
         if (lead_first) begin
            // delayed-clock format: first bit goes out with chip select
            sdo_q <= load_data[WORD_W-1];
            tx_q  <= {load_data[WORD_W-2:0], 1'b0};
         end else begin
            sdo_q <= 1'b1;
            tx_q  <= load_data;
         end
      end else begin
         if (shift_out) begin
            sdo_q <= tx_q[WORD_W-1];
            tx_q  <= {tx_q[WORD_W-2:0], 1'b0};
         end
         if (finish)
            sdo_q <= 1'b1;
         if (sample)
            rx_q <= {rx_q[WORD_W-2:0], sdi};
      end
   end

   assign sdo     = sdo_q;
   assign rx_data = rx_q;
endmodule

// File: rtl/spi_fmt_master.sv
module spi_fmt_master
   import spi_fmt_pkg::*;
#(
   parameter int WORD_W = 8,
   parameter int DIV_W  = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              start_i,
   input  logic [WORD_W-1:0] tx_byte_i,
   input  logic              pol_i,
   input  logic              pha_i,
   input  logic              cs_hi_i,
   input  logic [DIV_W-1:0]  div_i,
   output logic [WORD_W-1:0] rx_byte_o,
   output logic              busy_o,
   output logic              done_o,
   output logic              sclk_o,
   output logic              sdo_o,
   input  logic              sdi_i,
   output logic              cs_o
);
   localparam int EDGES  = 2 * WORD_W;
   localparam int ECNT_W = $clog2(EDGES);
   localparam logic [ECNT_W-1:0] LAST_EDGE = ECNT_W'(EDGES - 1);

   generate
      if (WORD_W < 2) begin : g_chk_word
         $error("spi_fmt_master: WORD_W must be at least 2");
      end
      if (DIV_W < 1) begin : g_chk_div
         $error("spi_fmt_master: DIV_W must be at least 1");
      end
   endgenerate

   spi_st_t            st_q;
   spi_fmt_t           fmt_q;
   logic [DIV_W-1:0]   div_q;
   logic [ECNT_W-1:0]  edge_q;
   logic               sclk_q;
   logic               done_q;

   logic               busy;
   logic               accept;
   logic [DIV_W-1:0]   div_sel;
   logic               tick;
   logic               edge_ev;
   logic               even_edge;
   logic               last_edge;
   logic               shift_ev;
   logic               sample_ev;
   logic               finish_ev;
   logic               sdo_w;
   logic [WORD_W-1:0]  rx_w;

   assign busy    = (st_q != ST_IDLE);
   assign accept  = start_i && !busy;
   // timebase preloads from the live setting while idle
   assign div_sel = busy ? div_q : div_i;

   spi_fmt_tick #(.DIV_W(DIV_W)) u_tick (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (busy),
      .div  (div_sel),
      .tick (tick)
   );

   assign edge_ev   = tick && (st_q == ST_SHIFT);
   assign even_edge = ~edge_q[0];
   assign last_edge = (edge_q == LAST_EDGE);
   assign finish_ev = tick && (st_q == ST_TAIL);

   // even edges lead (leave idle level), odd edges trail
   always_comb begin
      if (fmt_q.pha) begin
         shift_ev  = edge_ev && even_edge;
         sample_ev = edge_ev && !even_edge;
      end else begin
         shift_ev  = edge_ev && !even_edge && !last_edge;
         sample_ev = edge_ev && even_edge;
      end
   end

   spi_fmt_shreg #(.WORD_W(WORD_W)) u_shreg (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (accept),
      .lead_first(!pha_i),
      .load_data (tx_byte_i),
      .shift_out (shift_ev),
      .sample    (sample_ev),
      .finish    (finish_ev),
      .sdi       (sdi_i),
      .sdo       (sdo_w),
      .rx_data   (rx_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st_q   <= ST_IDLE;
         fmt_q  <= '0;
         div_q  <= '0;
         edge_q <= '0;
         sclk_q <= 1'b0;
         done_q <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (st_q)
            ST_IDLE: begin
               if (start_i) begin
                  st_q   <= ST_SHIFT;
                  fmt_q  <= '{pol: pol_i, pha: pha_i, cs_hi: cs_hi_i};
                  div_q  <= div_i;
                  edge_q <= '0;
                  sclk_q <= pol_i;
               end
            end
            ST_SHIFT: begin
               if (tick) begin
                  sclk_q <= ~sclk_q;
                  edge_q <= edge_q + 1'b1;
                  if (last_edge)
                     st_q <= ST_TAIL;
               end
            end
            ST_TAIL: begin
               if (tick) begin
                  st_q   <= ST_IDLE;
                  done_q <= 1'b1;
               end
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o    = busy;
   assign done_o    = done_q;
   assign rx_byte_o = rx_w;
   assign sdo_o     = sdo_w;
   assign sclk_o    = busy ? sclk_q : pol_i;
   assign cs_o      = busy ? fmt_q.cs_hi : ~cs_hi_i;
endmodule

// File: rtl/spi_fmt_master_chk.sv
module spi_fmt_master_chk (
   input logic clk,
   input logic rst_n,
   input logic start_i,
   input logic pol_i,
   input logic cs_hi_i,
   input logic busy_o,
   input logic done_o,
   input logic sclk_o,
   input logic sdo_o,
   input logic cs_o
);
   logic pol_l;
   logic cs_hi_l;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pol_l   <= 1'b0;
         cs_hi_l <= 1'b0;
      end else if (start_i && !busy_o) begin
         pol_l   <= pol_i;
         cs_hi_l <= cs_hi_i;
      end
   end

   AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> !done_o); // R6
   AST_DONE_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |-> (!busy_o && $past(busy_o))); // R6
   AST_BUSY_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy_o) |-> $past(start_i)); // R8
   AST_SDO_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      !busy_o |-> sdo_o); // R9
   AST_CS_HELD: assert property (@(posedge clk) disable iff (!rst_n)
      busy_o |-> (cs_o == cs_hi_l)); // R7
   AST_SCLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> ($past(sclk_o) == pol_l)); // R1
endmodule

bind spi_fmt_master spi_fmt_master_chk u_chk (
   .clk    (clk),
   .rst_n  (rst_n),
   .start_i(start_i),
   .pol_i  (pol_i),
   .cs_hi_i(cs_hi_i),
   .busy_o (busy_o),
   .done_o (done_o),
   .sclk_o (sclk_o),
   .sdo_o  (sdo_o),
   .cs_o   (cs_o)
);

// File: tb/sim_spi_fmt_master.sv
`timescale 1ns/1ps
module sim_spi_fmt_master;
   localparam int W = 8;
   localparam int DW = 8;
   localparam time CLK_P = 5ns;

   typedef struct packed {
      logic       pol;
      logic       pha;
      logic       cshi;
      logic [7:0] div;
      logic [7:0] tx;
      logic [7:0] sl;
   } vec_t;

   localparam vec_t VECS [8] = '{
      '{1'b0, 1'b0, 1'b0, 8'd1, 8'hA5, 8'h3C},
      '{1'b1, 1'b0, 1'b0, 8'd2, 8'h96, 8'hC1},
      '{1'b0, 1'b1, 1'b1, 8'd1, 8'h5A, 8'h81},
      '{1'b1, 1'b1, 1'b0, 8'd3, 8'hF0, 8'h0F},
      '{1'b0, 1'b0, 1'b1, 8'd4, 8'h01, 8'h80},
      '{1'b1, 1'b1, 1'b1, 8'd2, 8'h80, 8'h7E},
      '{1'b0, 1'b1, 1'b0, 8'd0, 8'hC3, 8'hE7},
      '{1'b1, 1'b0, 1'b1, 8'd1, 8'hFF, 8'h00}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [W-1:0]  tx_byte_i = '0;
   logic          pol_i = 1'b1;
   logic          pha_i = 1'b0;
   logic          cs_hi_i = 1'b1;
   logic [DW-1:0] div_i = 8'd1;
   logic [W-1:0]  rx_byte_o;
   logic          busy_o, done_o, sclk_o, sdo_o, cs_o;
   logic          sdi_i = 1'b1;

   int n_chk = 0;
   int n_fail = 0;
   int cyc = 0;

   // bench slave / monitor state
   logic       mon_en = 1'b0;
   logic       mon_pol, mon_pha, mon_cs;
   logic       prev_sclk;
   logic [7:0] slave_b = '0;
   logic [7:0] cap_tx;
   int         smp_k, n_lead, n_trail, n_done, cs_bad;
   int         cs_on, cs_off, first_edge, last_edge;
   logic       cs_seen, off_seen, sdo_at_cs;

   spi_fmt_master #(.WORD_W(W), .DIV_W(DW)) u0 (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .tx_byte_i(tx_byte_i),
      .pol_i(pol_i), .pha_i(pha_i), .cs_hi_i(cs_hi_i), .div_i(div_i),
      .rx_byte_o(rx_byte_o), .busy_o(busy_o), .done_o(done_o),
      .sclk_o(sclk_o), .sdo_o(sdo_o), .sdi_i(sdi_i), .cs_o(cs_o)
   );

   always #(CLK_P/2) clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   // monitor: classifies serial clock edges, models the slave
   always @(negedge clk) begin
      if (mon_en) begin
         if (cs_o == mon_cs && !cs_seen) begin
            cs_seen = 1'b1; cs_on = cyc; sdo_at_cs = sdo_o;
         end
         if (cs_seen && !off_seen && cs_o != mon_cs) begin
            off_seen = 1'b1; cs_off = cyc;
         end
         if (sclk_o != prev_sclk) begin
            if (cs_o != mon_cs) cs_bad++;
            if (n_lead + n_trail == 0) first_edge = cyc;
            last_edge = cyc;
            if (sclk_o != mon_pol) n_lead++; else n_trail++;
            if ((sclk_o != mon_pol) != mon_pha) begin
               cap_tx = {cap_tx[6:0], sdo_o};
               smp_k++;
            end
            prev_sclk = sclk_o;
         end
         if (done_o) n_done++;
         sdi_i = (smp_k < 8) ? slave_b[7 - smp_k] : 1'b1;
      end
   end

   task automatic xfer(input vec_t v, input bit disturb);
      int guard;
      int eff;
      eff = (v.div == 0) ? 1 : int'(v.div);
      @(negedge clk);
      pol_i = v.pol; pha_i = v.pha; cs_hi_i = v.cshi; div_i = v.div;
      tx_byte_i = v.tx; slave_b = v.sl;
      mon_pol = v.pol; mon_pha = v.pha; mon_cs = v.cshi; prev_sclk = v.pol;
      cap_tx = '0; smp_k = 0; n_lead = 0; n_trail = 0; n_done = 0; cs_bad = 0;
      cs_seen = 1'b0; off_seen = 1'b0; cs_on = 0; cs_off = 0;
      first_edge = 0; last_edge = 0; sdo_at_cs = 1'b0;
      sdi_i = v.sl[7];
      mon_en = 1'b1;
      @(negedge clk);
      start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (disturb) begin
         repeat (6) @(negedge clk);
         // R8: altered inputs with a start while busy
         pha_i = ~v.pha; cs_hi_i = ~v.cshi; div_i = 8'd1;
         tx_byte_i = ~v.tx; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0; pha_i = v.pha; cs_hi_i = v.cshi;
         div_i = v.div; tx_byte_i = v.tx;
      end
      guard = 0;
      while (!done_o && guard < 5000) begin
         @(negedge clk);
         guard++;
      end
      check(rx_byte_o == v.sl, "R6 received word", rx_byte_o, v.sl);
      @(negedge clk);
      mon_en = 1'b0;
      check(cap_tx == v.tx, "R4 MSB-first data out", cap_tx, v.tx);
      check(n_lead == 8, "R4 leading edges", n_lead, 8);
      check(n_trail == 8, "R4 trailing edges", n_trail, 8);
      check(n_done == 1, "R6 single done pulse", n_done, 1);
      check(cs_bad == 0, "R7 cs active at every edge", cs_bad, 0);
      check(first_edge - cs_on == eff, "R7 cs lead / R5 half bit", first_edge - cs_on, eff);
      check(cs_off - last_edge == eff, "R7 cs lag / R5 half bit", cs_off - last_edge, eff);
      if (v.pha)
         check(sdo_at_cs == 1'b1, "R2 sdo high before first edge", sdo_at_cs, 1);
      else
         check(sdo_at_cs == v.tx[7], "R3 first bit before first edge", sdo_at_cs, v.tx[7]);
      check(sclk_o == v.pol, "R1 clock parked at idle", sclk_o, v.pol);
      check(sdo_o == 1'b1, "R9 sdo high when idle", sdo_o, 1);
      check(busy_o == 1'b0, "R8 no second transfer", busy_o, 0);
   endtask

   initial begin
      #(CLK_P * 200000);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      // reset state (R1, R7, R9)
      repeat (3) @(negedge clk);
      check(sclk_o == 1'b1, "R1 reset clock idle level", sclk_o, 1);
      check(cs_o == 1'b0, "R1 reset cs inactive", cs_o, 0);
      check(sdo_o == 1'b1, "R9 reset sdo high", sdo_o, 1);
      check(busy_o == 1'b0 && done_o == 1'b0, "R1 reset busy/done low", {busy_o, done_o}, 0);
      rst_n = 1'b1;
      @(negedge clk);
      pol_i = 1'b0;
      @(negedge clk);
      check(sclk_o == 1'b0, "R1 idle clock follows polarity", sclk_o, 0);

      // vector table: all four formats, both cs levels, divider 0..4
      for (int i = 0; i < 8; i++) xfer(VECS[i], 1'b0);

      // directed: start while busy with altered inputs (R8)
      xfer('{1'b1, 1'b0, 1'b0, 8'd3, 8'h69, 8'hB4}, 1'b1);
      xfer('{1'b0, 1'b1, 1'b1, 8'd2, 8'h3E, 8'h5D}, 1'b1);
      repeat (10) @(negedge clk);
      check(busy_o == 1'b0, "R8 ignored start left idle", busy_o, 0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule